// File: doc/BRIEF.md
# Serial Data-Out Path for a 16-bit DAC Interface

This block drives the single serial output pin of a 16-bit serial DAC port. The pin has two possible sources. In readback mode it carries a separate word that is captured when a read command completes, and it is driven only during the frame that follows that command. In either chain mode it carries the bit leaving the far end of the input shift register, so several devices can be wired output-to-input and fed as one long shift path.

The two sources behave differently when the port is idle. The readback path releases the pin by dropping the output enable. The chain path holds the pin high so that the data input of the next device never floats. The block also produces a one-cycle end-of-cycle strobe for the command decoder. In readback mode the strobe follows the 16th falling serial-clock edge. In the chain modes it follows the deassertion of chip select.

The block runs on one system clock. `cs_n`, `sclk` and `sdi` must already be synchronous to that clock, and each serial-clock level must last at least one system clock. The serial clock idles high. Data is sampled on its falling edge, most significant bit first.

Top module: `serial_dout_path`

## Requirements
- R1: During reset and right after it, `eoc` is 0. In readback mode (`mode`=0) with `cs_n` high, `sdo_oe` is 0. In a chain mode with `cs_n` high, `sdo_oe` is 1 and `sdo` is 1.
- R2: Each falling edge of `sclk` while `cs_n` is low shifts `sdi` into the low end of a 16-bit shift register. The first bit received is therefore the first to leave the top.
- R3: In a chain mode, `sdo` stays 1 within a frame until 16 falling edges have been received. After that it carries the bit received 16 falling edges earlier.
- R4: With `mode`=1, the chain output changes on the falling edge of `sclk`. After falling edge k (k of 16 or more) it shows input bit k-16.
- R5: With `mode`=2 or `mode`=3, the chain output changes on the rising edge of `sclk`. After falling edge k it still shows the value loaded at the previous rising edge. After the rising edge that follows falling edge k, it shows input bit k-16.
- R6: In a chain mode, `sdo` is 1 and `sdo_oe` is 1 whenever `cs_n` is high.
- R7: `eoc` is a single-cycle pulse, registered one clock after the event. In readback mode the event is the 16th falling `sclk` edge of a frame. In a chain mode it is the rising edge of `cs_n`. No other event raises it.
- R8: If `rd_cmd` is high in any cycle of a frame while `cs_n` is low, `rb_word` is captured at that frame's end of cycle. In the next frame, `sdo_oe` is 1 from the fall of `cs_n`, `sdo` starts with bit 15 of the captured word, and each rising `sclk` edge advances to the next lower bit. The word is captured in any mode, but only readback mode sends it.
- R9: In readback mode, `sdo_oe` is 0 in three cases: while `cs_n` is high, during the read-command frame itself, and during any frame not preceded by a read-command frame.
- R10: In readback mode, falling edges after the 16th within a frame produce no further `eoc`. After the 16th falling edge, `sdo_oe` returns to 0 for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| sclk | input | 1 | Serial clock, idles high, synchronous to clk |
| sdi | input | 1 | Serial data in, sampled on falling sclk |
| mode | input | 2 | 0 readback, 1 chain on falling edge, 2 or 3 chain on rising edge |
| rd_cmd | input | 1 | High during a frame decoded as a read command |
| rb_word | input | W | Word to read back, captured at end of cycle |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the pin's tri-state driver |
| eoc | output | 1 | One-cycle end-of-cycle strobe |

## Verification
The bench sweeps every chain mode with frames shorter than, equal to, and longer than 16 bits. It predicts every output bit from the pseudo-random input stream. A design with the wrong edge alignment would show the correct bit half a serial clock early or late. A design that did not hold the output high would leak stale shift-register bits before 16 bits had arrived.

Back-to-back readback frames are run in which each frame both sends the previous word and captures the next. A design that enabled the driver as soon as the word was captured would drive the pin during the command frame itself. A design that let the capture overwrite the shifter too early would corrupt the outgoing word.

Readback frames with extra clock edges are also run. A counter that wrapped instead of saturating would emit a second end-of-cycle strobe and would re-enable the pin.

// File: rtl/dout_pkg.sv
package dout_pkg;

    typedef enum logic [1:0] {
        OUT_READBACK   = 2'd0,
        OUT_CHAIN_FALL = 2'd1,
        OUT_CHAIN_RISE = 2'd2,
        OUT_CHAIN_ALT  = 2'd3
    } out_mode_e;

endpackage

// File: rtl/dout_frame.sv
module dout_frame #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          rb_mode,
    output logic          sclk_fall,
    output logic          sclk_rise,
    output logic          cs_fall,
    output logic [CW-1:0] bit_cnt,
    output logic          eoc_now,
    output logic          eoc_q
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    typedef struct packed {
        logic          sclk;
        logic          cs;
        logic [CW-1:0] cnt;
        logic          eoc;
    } frame_t;

    frame_t fr_q, fr_d;
    logic   cs_rise;

    always_comb begin
        sclk_fall = fr_q.sclk & ~sclk & ~cs_n;
        sclk_rise = ~fr_q.sclk & sclk & ~cs_n;
        cs_fall   = fr_q.cs & ~cs_n;
        cs_rise   = ~fr_q.cs & cs_n;
        eoc_now   = rb_mode ? (sclk_fall && fr_q.cnt == LAST) : cs_rise;

        fr_d.sclk = sclk;
        fr_d.cs   = cs_n;
        fr_d.eoc  = eoc_now;
        if (cs_n)
            fr_d.cnt = '0;
        else if (sclk_fall && fr_q.cnt != FULL)
            fr_d.cnt = fr_q.cnt + 1'b1;
        else
            fr_d.cnt = fr_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fr_q <= '{sclk: 1'b1, cs: 1'b1, cnt: '0, eoc: 1'b0};
        else
            fr_q <= fr_d;
    end

    assign bit_cnt = fr_q.cnt;
    assign eoc_q   = fr_q.eoc;

    // The bit counter saturates and never passes the word length (R10)
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.cnt <= FULL);

    // The end-of-cycle strobe lasts exactly one cycle (R7)
    assert_eoc_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.eoc |=> !fr_q.eoc);

endmodule

// File: rtl/dout_chain.sv
module dout_chain #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sdi,
    input  logic          sclk_fall,
    input  logic          sclk_rise,
    input  logic          rise_mode,
    input  logic [CW-1:0] bit_cnt,
    output logic          chain_bit
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    typedef struct packed {
        logic [W-1:0] sr;
        logic         dz;
    } chain_t;

    chain_t ch_q, ch_d;

    always_comb begin
        ch_d = ch_q;
        if (sclk_fall)
            ch_d.sr = {ch_q.sr[W-2:0], sdi};

        if (cs_n)
            ch_d.dz = 1'b1;
        else if (!rise_mode && sclk_fall)
            ch_d.dz = (bit_cnt >= LAST) ? ch_d.sr[W-1] : 1'b1;
        else if (rise_mode && sclk_rise)
            ch_d.dz = (bit_cnt == FULL) ? ch_q.sr[W-1] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ch_q <= '{sr: '0, dz: 1'b1};
        else
            ch_q <= ch_d;
    end

    assign chain_bit = ch_q.dz;

    // Before a full word has entered this frame, the chain output holds high (R3)
    assert_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && bit_cnt != FULL) |-> ch_q.dz);

endmodule

// File: rtl/dout_readback.sv
module dout_readback #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         cs_fall,
    input  logic         sclk_rise,
    input  logic         eoc_now,
    input  logic         rd_cmd,
    input  logic [W-1:0] rb_word,
    output logic         rb_oe,
    output logic         rb_bit
);
    typedef struct packed {
        logic         seen;
        logic         pend;
        logic         arm;
        logic [W-1:0] sh;
    } rback_t;

    rback_t rb_q, rb_d;
    logic   load;

    always_comb begin
        rb_d = rb_q;
        load = eoc_now & (rb_q.seen | (rd_cmd & ~cs_n));

        rb_d.seen = cs_n ? 1'b0 : (rb_q.seen | rd_cmd);

        if (load)
            rb_d.pend = 1'b1;
        else if (cs_fall)
            rb_d.pend = 1'b0;

        if (cs_n || eoc_now)
            rb_d.arm = 1'b0;
        else if (cs_fall)
            rb_d.arm = rb_q.pend;

        if (load)
            rb_d.sh = rb_word;
        else if (rb_q.arm && sclk_rise)
            rb_d.sh = {rb_q.sh[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rb_q <= '{seen: 1'b0, pend: 1'b0, arm: 1'b0, sh: '0};
        else
            rb_q <= rb_d;
    end

    assign rb_oe  = ~cs_n & rb_q.arm;
    assign rb_bit = rb_q.sh[W-1];

    // The driver only arms when a captured word was waiting (R8)
    assert_arm_needs_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_q.arm) |-> $past(rb_q.pend));

    // The driver is released once the frame's end of cycle passes (R10)
    assert_disarm_after_eoc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_now |=> !rb_q.arm);

endmodule

// File: rtl/serial_dout_path.sv
module serial_dout_path
    import dout_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         sdi,
    input  logic [1:0]   mode,
    input  logic         rd_cmd,
    input  logic [W-1:0] rb_word,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         eoc
);
    localparam int CW = $clog2(W + 1);

    out_mode_e     mode_e;
    logic          rb_mode, rise_mode;
    logic          sclk_fall, sclk_rise, cs_fall, eoc_now;
    logic [CW-1:0] bit_cnt;
    logic          chain_bit, rb_oe, rb_bit;

    assign mode_e    = out_mode_e'(mode);
    assign rb_mode   = (mode_e == OUT_READBACK);
    assign rise_mode = (mode_e == OUT_CHAIN_RISE) || (mode_e == OUT_CHAIN_ALT);

    dout_frame #(.W(W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .rb_mode   (rb_mode),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .cs_fall   (cs_fall),
        .bit_cnt   (bit_cnt),
        .eoc_now   (eoc_now),
        .eoc_q     (eoc)
    );

    dout_chain #(.W(W)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .rise_mode (rise_mode),
        .bit_cnt   (bit_cnt),
        .chain_bit (chain_bit)
    );

    dout_readback #(.W(W)) u_rback (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_fall   (cs_fall),
        .sclk_rise (sclk_rise),
        .eoc_now   (eoc_now),
        .rd_cmd    (rd_cmd),
        .rb_word   (rb_word),
        .rb_oe     (rb_oe),
        .rb_bit    (rb_bit)
    );

    always_comb begin
        if (rb_mode) begin
            sdo_oe = rb_oe;
            sdo    = rb_oe ? rb_bit : 1'b1;
        end else begin
            sdo_oe = 1'b1;
            sdo    = cs_n ? 1'b1 : chain_bit;
        end
    end

    // The readback pin is released whenever chip select is high (R9)
    assert_rb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_mode && cs_n) |-> !sdo_oe);

    // In the chain modes the idle pin is driven high (R6)
    assert_chain_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_mode && cs_n) |-> (sdo && sdo_oe));

endmodule

// File: tb/serial_dout_path_test.sv
module serial_dout_path_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b1;
    logic         sdi = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         rd_cmd = 1'b0;
    logic [W-1:0] rb_word = '0;
    logic         sdo, sdo_oe, eoc;

    int n_chk = 0;
    int n_bad = 0;
    int eoc_cnt = 0;

    always #10 clk = ~clk;

    always @(negedge clk) if (eoc === 1'b1) eoc_cnt++;

    serial_dout_path #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .mode(mode), .rd_cmd(rd_cmd), .rb_word(rb_word),
        .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #2;
    endtask

    task automatic chain_frame(int nbits, logic [7:0] seed);
        logic [255:0] s;
        logic [7:0]   lf;
        logic         e;
        int           e0;
        lf = seed;
        s  = '0;
        for (int i = 0; i < nbits; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            s[i] = lf[0];
        end
        e0 = eoc_cnt;
        cs_n = 1'b0;
        settle();
        chk("R3 chain start high", {31'd0, sdo}, 32'd1);
        for (int k = 1; k <= nbits; k++) begin
            sdi  = s[k-1];
            sclk = 1'b0;
            settle();
            if (mode == 2'd1) e = (k >= W) ? s[k-W] : 1'b1;
            else              e = (k - 1 >= W) ? s[k-1-W] : 1'b1;
            chk((mode == 2'd1) ? "R4 chain after fall" : "R5 chain after fall",
                {31'd0, sdo}, {31'd0, e});
            sclk = 1'b1;
            settle();
            e = (k >= W) ? s[k-W] : 1'b1;
            chk((mode == 2'd1) ? "R4 chain after rise" : "R5 chain after rise",
                {31'd0, sdo}, {31'd0, e});
            chk("R2 chain oe in frame", {31'd0, sdo_oe}, 32'd1);
        end
        chk("R7 no chain eoc before cs rise", eoc_cnt, e0);
        cs_n = 1'b1;
        settle();
        chk("R6 chain idle sdo", {31'd0, sdo}, 32'd1);
        chk("R6 chain idle oe", {31'd0, sdo_oe}, 32'd1);
        chk("R7 chain eoc at cs rise", eoc_cnt, e0 + 1);
    endtask

    task automatic rb_frame(int nedges, bit do_read, logic [W-1:0] word,
                            bit expect_out, logic [W-1:0] prev);
        int e0;
        bit drive;
        e0 = eoc_cnt;
        rb_word = word;
        cs_n = 1'b0;
        settle();
        chk(expect_out ? "R8 oe at frame start" : "R9 quiet at frame start",
            {31'd0, sdo_oe}, {31'd0, expect_out});
        if (expect_out) chk("R8 first bit", {31'd0, sdo}, {31'd0, prev[W-1]});
        for (int k = 1; k <= nedges; k++) begin
            if (do_read) rd_cmd = (k == 4);
            sdi  = k[0];
            sclk = 1'b0;
            settle();
            drive = expect_out && (k < W);
            chk(expect_out ? "R10 oe after fall" : "R9 quiet after fall",
                {31'd0, sdo_oe}, {31'd0, drive});
            if (drive) chk("R8 bit held over fall", {31'd0, sdo}, {31'd0, prev[W-k]});
            if (k == W - 1) chk("R7 no eoc before 16th fall", eoc_cnt, e0);
            if (k == W)     chk("R7 eoc after 16th fall", eoc_cnt, e0 + 1);
            sclk = 1'b1;
            settle();
            chk(expect_out ? "R10 oe after rise" : "R9 quiet after rise",
                {31'd0, sdo_oe}, {31'd0, drive});
            if (drive) chk("R8 bit after rise", {31'd0, sdo}, {31'd0, prev[W-1-k]});
        end
        chk("R10 single eoc per frame", eoc_cnt, e0 + ((nedges >= W) ? 1 : 0));
        rd_cmd = 1'b0;
        cs_n = 1'b1;
        settle();
        chk("R9 released with cs high", {31'd0, sdo_oe}, 32'd0);
    endtask

    initial begin
        logic [W-1:0] wa [3];
        logic [W-1:0] wb [3];
        wa[0] = 16'hA5C3; wb[0] = 16'h3C5A;
        wa[1] = 16'hFFFF; wb[1] = 16'h0001;
        wa[2] = 16'h8000; wb[2] = 16'h7FFE;

        repeat (3) @(negedge clk);
        #2;
        chk("R1 eoc in reset", {31'd0, eoc}, 32'd0);
        rst_n = 1'b1;
        settle();
        chk("R1 eoc after reset", {31'd0, eoc}, 32'd0);
        chk("R1 readback idle oe", {31'd0, sdo_oe}, 32'd0);
        mode = 2'd1;
        settle();
        chk("R1 chain idle oe", {31'd0, sdo_oe}, 32'd1);
        chk("R1 chain idle sdo", {31'd0, sdo}, 32'd1);

        for (int m = 1; m <= 3; m++) begin
            mode = m[1:0];
            settle();
            chain_frame(32, 8'h5B + 8'(m));
            chain_frame(24, 8'hC1 + 8'(m));
            chain_frame(16, 8'h37 + 8'(m));
            chain_frame(8,  8'h9E + 8'(m));
        end

        mode = 2'd0;
        settle();
        for (int p = 0; p < 3; p++) begin
            rb_frame(16, 1'b0, '0,    1'b0, '0);
            rb_frame(16, 1'b1, wa[p], 1'b0, '0);
            rb_frame(16, 1'b1, wb[p], 1'b1, wa[p]);
            rb_frame(20, 1'b0, '0,    1'b1, wb[p]);
            rb_frame(20, 1'b0, '0,    1'b0, '0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule